// File: doc/BRIEF.md
# Two-Axis Step Pulse Sequencer

This block plays back step schedules for two stepper motor drivers. These schedules are worked out earlier, elsewhere. A command carries a kind code, one direction bit for each motor, and a fixed number of 32-bit step entries. The entries for both motors share one list. Bit 31 of each entry chooses the motor, and the lower 31 bits give the time to wait after that step.

Commands go into a small circular queue. This lets the next move be loaded while the current one is still running. A single engine works through the head command one entry at a time:

1. It sets the chosen motor's direction line.
2. After a setup gap, it raises that motor's step line for a fixed pulse width.
3. It counts the entry's interval on a prescaled tick before taking the next entry.

A command is retired when its last entry has finished, or as soon as it reaches an entry with a zero interval. A command whose kind is not zero is a stop. A stop empties the queue at once and drops both step lines.

Top module: `step_seq_top`

## Requirements
- R1: After reset, both step lines and both direction lines are low, `empty_o` is 1, and `full_o` and `overflow_o` are 0.
- R2: Entry k sits at `cmd_steps_i[32k+31:32k]`. Its bit 31 selects the motor (0 gives motor 0, 1 gives motor 1), and bits 30:0 hold the interval. In `cmd_dir_i`, bit 0 is the direction for motor 0 and bit 1 is the direction for motor 1.
- R3: Before each step, the selected motor's direction line is driven to that motor's bit in the command. The line then holds steady for at least SETUP_CYCLES (at least 2) clock cycles before the step line rises.
- R4: Each step pulse stays high for exactly PULSE_CYCLES clock cycles, unless a stop cuts it short. At most one step line is high at any time.
- R5: With PRESCALE = 1 and an interval I of at least PULSE_CYCLES, two steps from the same command rise exactly I + SETUP_CYCLES + 2 cycles apart. With a larger PRESCALE, the interval is counted in prescaler ticks.
- R6: The entries of a command are carried out in array order, with one step for each entry. After the wait of its last entry, the command leaves the queue.
- R7: An entry with a zero interval produces no step. It retires the command at once, and the entries after it are skipped.
- R8: Commands run in the order they were written. A write is accepted while an earlier command is running. `full_o` is 1 once QUEUE_DEPTH commands are held, counting the one that is running.
- R9: A normal write that arrives while the queue is full is dropped. It sets `overflow_o`, which stays at 1 until reset, and the commands already held still run.
- R10: A write whose kind is not zero is not queued. It empties the queue and aborts the running command. On the next cycle both step lines are low and `empty_o` is 1, and no further steps follow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command write strobe, one cycle per command |
| cmd_kind_i | input | 8 | 0 = move, any other value = stop |
| cmd_dir_i | input | 2 | Direction bit for each motor |
| cmd_steps_i | input | 32*N_ENTRIES | Interleaved step entries |
| step_o | output | 2 | Step lines, one per motor |
| dir_o | output | 2 | Direction lines, one per motor |
| full_o | output | 1 | Queue holds QUEUE_DEPTH commands |
| empty_o | output | 1 | No command held or running |
| overflow_o | output | 1 | Sticky flag: a write was dropped |

## Verification
Two pairs of functions can fall in the same cycle:

- **Stop during a pulse.** A stop can arrive while a step pulse is high and another move is waiting in the queue. The bench provokes this by issuing the stop at the first observed rising edge of a two-command sequence. It judges the result by a low step line and `empty_o` high on the very next cycle, and by no further rising edge over the following few hundred cycles.
- **Write against a full queue.** A write can meet a full queue while the engine is still busy with the head command. The bench fills a two-deep queue back to back and then writes a third move. It judges the result by the sticky flag, and by an event log that holds exactly the first two commands in order.

// File: rtl/step_seq_pkg.sv
package step_seq_pkg;
  localparam int ENTRY_W = 32;
  localparam int CMD_HDR = 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ENTRY,
    ST_SETUP,
    ST_PULSE,
    ST_WAIT
  } eng_state_e;
endpackage

// File: rtl/seq_tick_gen.sv
module seq_tick_gen #(
  parameter int PRESCALE = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  generate
    if (PRESCALE <= 1) begin : g_direct
      assign tick_o = 1'b1;
    end else begin : g_div
      localparam int PW = $clog2(PRESCALE);
      logic [PW-1:0] div_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                          div_q <= '0;
        else if (div_q == PW'(PRESCALE - 1))  div_q <= '0;
        else                                  div_q <= div_q + 1'b1;
      end
      assign tick_o = (div_q == PW'(PRESCALE - 1));
    end
  endgenerate
endmodule

// File: rtl/seq_cmd_queue.sv
module seq_cmd_queue #(
  parameter int DEPTH = 4,
  parameter int W     = 130
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic         pop_i,
  input  logic         flush_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] head_o,
  output logic         full_o,
  output logic         empty_o,
  output logic         overflow_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [CNT_W-1:0] cnt_q;
  logic             ovf_q;
  logic             accept, take;

  assign full_o     = (cnt_q == CNT_W'(DEPTH));
  assign empty_o    = (cnt_q == '0);
  assign overflow_o = ovf_q;
  assign head_o     = mem_q[rd_q];
  assign accept     = push_i && !full_o && !flush_i;
  assign take       = pop_i && !empty_o && !flush_i;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (accept) mem_q[wr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else if (flush_i) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (accept) wr_q <= nxt(wr_q);
      if (take)   rd_q <= nxt(rd_q);
      if (accept && !take)      cnt_q <= cnt_q + 1'b1;
      else if (take && !accept) cnt_q <= cnt_q - 1'b1;
      if (push_i && full_o) ovf_q <= 1'b1;
    end
  end

  a_r9_overflow_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o |=> overflow_o);
  a_r9_drop_when_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full_o && !pop_i && !flush_i) |=> (full_o && overflow_o));
  a_r10_flush_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> empty_o);
  a_r8_pop_needs_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
endmodule

// File: rtl/seq_step_engine.sv
module seq_step_engine
  import step_seq_pkg::*;
#(
  parameter int N_ENTRIES    = 4,
  parameter int PULSE_CYCLES = 100,
  parameter int SETUP_CYCLES = 2,
  parameter int CMD_W        = CMD_HDR + ENTRY_W * N_ENTRIES
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             flush_i,
  input  logic             head_valid_i,
  input  logic [CMD_W-1:0] head_i,
  output logic             pop_o,
  output logic [1:0]       step_o,
  output logic [1:0]       dir_o
);
  localparam int IDX_W = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1;
  localparam int CMAX  = (PULSE_CYCLES > SETUP_CYCLES) ? PULSE_CYCLES : SETUP_CYCLES;
  localparam int CNT_W = $clog2(CMAX + 1);
  localparam int IVL_W = ENTRY_W - 1;

  eng_state_e       state_q;
  logic [IDX_W-1:0] idx_q;
  logic [CNT_W-1:0] cnt_q;
  logic [IVL_W-1:0] wcnt_q;
  logic [1:0]       step_q, dir_q;
  logic             mot_q;

  logic [ENTRY_W-1:0] entry_w;
  logic               motor_w, last_w;
  logic [IVL_W-1:0]   ivl_w;

  assign entry_w = head_i[CMD_HDR + ENTRY_W * int'(idx_q) +: ENTRY_W];
  assign motor_w = entry_w[ENTRY_W-1];
  assign ivl_w   = entry_w[IVL_W-1:0];
  assign last_w  = (idx_q == IDX_W'(N_ENTRIES - 1));
  assign step_o  = step_q;
  assign dir_o   = dir_q;

  always_comb begin
    pop_o = 1'b0;
    if (!flush_i) begin
      if (state_q == ST_ENTRY && ivl_w == '0)               pop_o = 1'b1;
      if (state_q == ST_WAIT && wcnt_q == '0 && last_w)     pop_o = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      cnt_q   <= '0;
      wcnt_q  <= '0;
      step_q  <= '0;
      dir_q   <= '0;
      mot_q   <= 1'b0;
    end else if (flush_i) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      wcnt_q  <= '0;
      step_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (head_valid_i) begin
            idx_q   <= '0;
            state_q <= ST_ENTRY;
          end
        end
        ST_ENTRY: begin
          if (ivl_w == '0) begin
            state_q <= ST_IDLE;
          end else begin
            dir_q[motor_w] <= head_i[motor_w];
            mot_q          <= motor_w;
            cnt_q          <= CNT_W'(SETUP_CYCLES - 1);
            state_q        <= ST_SETUP;
          end
        end
        ST_SETUP: begin
          if (cnt_q == '0) begin
            step_q[mot_q] <= 1'b1;
            cnt_q         <= CNT_W'(PULSE_CYCLES - 1);
            wcnt_q        <= ivl_w;
            state_q       <= ST_PULSE;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        ST_PULSE: begin
          if (tick_i && wcnt_q != '0) wcnt_q <= wcnt_q - 1'b1;
          if (cnt_q == '0) begin
            step_q  <= '0;
            state_q <= ST_WAIT;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        ST_WAIT: begin
          if (wcnt_q == '0) begin
            if (last_w) begin
              state_q <= ST_IDLE;
            end else begin
              idx_q   <= idx_q + 1'b1;
              state_q <= ST_ENTRY;
            end
          end else if (tick_i) begin
            wcnt_q <= wcnt_q - 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  logic [31:0] hi_cnt_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            hi_cnt_q <= '0;
    else if (step_q != '0)  hi_cnt_q <= hi_cnt_q + 1;
    else                    hi_cnt_q <= '0;
  end

  a_r4_single_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(step_o));
  a_r4_pulse_width: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_q == '0 && hi_cnt_q != 0 && !$past(flush_i)) |-> (hi_cnt_q == PULSE_CYCLES));
  a_r10_flush_drops_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (step_o == '0));

  for (genvar m = 0; m < 2; m++) begin : g_chk
    a_r3_dir_setup: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(step_q[m]) |-> (dir_q[m] == $past(dir_q[m]) && dir_q[m] == $past(dir_q[m], 2)));
  end
endmodule

// File: rtl/step_seq_top.sv
module step_seq_top
  import step_seq_pkg::*;
#(
  parameter int N_ENTRIES    = 4,
  parameter int QUEUE_DEPTH  = 4,
  parameter int PULSE_CYCLES = 100,
  parameter int SETUP_CYCLES = 2,
  parameter int PRESCALE     = 1
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         cmd_valid_i,
  input  logic [7:0]                   cmd_kind_i,
  input  logic [1:0]                   cmd_dir_i,
  input  logic [ENTRY_W*N_ENTRIES-1:0] cmd_steps_i,
  output logic [1:0]                   step_o,
  output logic [1:0]                   dir_o,
  output logic                         full_o,
  output logic                         empty_o,
  output logic                         overflow_o
);
  localparam int CMD_W = CMD_HDR + ENTRY_W * N_ENTRIES;

  logic             push, stop, pop, tick;
  logic [CMD_W-1:0] head;

  assign stop = cmd_valid_i && (cmd_kind_i != 8'd0);
  assign push = cmd_valid_i && (cmd_kind_i == 8'd0);

  seq_tick_gen #(.PRESCALE(PRESCALE)) u_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_o(tick)
  );

  seq_cmd_queue #(.DEPTH(QUEUE_DEPTH), .W(CMD_W)) u_queue (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .push_i    (push),
    .pop_i     (pop),
    .flush_i   (stop),
    .data_i    ({cmd_steps_i, cmd_dir_i}),
    .head_o    (head),
    .full_o    (full_o),
    .empty_o   (empty_o),
    .overflow_o(overflow_o)
  );

  seq_step_engine #(
    .N_ENTRIES   (N_ENTRIES),
    .PULSE_CYCLES(PULSE_CYCLES),
    .SETUP_CYCLES(SETUP_CYCLES),
    .CMD_W       (CMD_W)
  ) u_engine (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick),
    .flush_i     (stop),
    .head_valid_i(!empty_o),
    .head_i      (head),
    .pop_o       (pop),
    .step_o      (step_o),
    .dir_o       (dir_o)
  );
endmodule

// File: tb/tb_step_seq_top.sv
module tb_step_seq_top;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 4;
  localparam int P  = 3;
  localparam int S  = 2;
  localparam int QD = 2;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cmd_valid = 1'b0;
  logic [7:0]   cmd_kind = '0;
  logic [1:0]   cmd_dir = '0;
  logic [N*32-1:0] cmd_steps = '0;
  logic [1:0]   step, dir;
  logic         full, empty, overflow;

  always #(CLK_PERIOD/2) clk = ~clk;

  step_seq_top #(.N_ENTRIES(N), .QUEUE_DEPTH(QD), .PULSE_CYCLES(P),
                 .SETUP_CYCLES(S), .PRESCALE(1)) dut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_kind_i(cmd_kind),
    .cmd_dir_i(cmd_dir), .cmd_steps_i(cmd_steps), .step_o(step), .dir_o(dir),
    .full_o(full), .empty_o(empty), .overflow_o(overflow));

  int n_chk = 0, n_fail = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // step event monitor
  int ev_mot [512], ev_dir [512], ev_t [512];
  int ev_n = 0, cyc = 0;
  int dir_chg [2] = '{-100, -100};
  int hi_len [2] = '{0, 0};
  bit aborted = 0;
  logic [1:0] pstep = '0, pdir = '0;

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (step == 2'b11) chk(0, "R4 both step lines high", 3, 1);
      for (int m = 0; m < 2; m++) begin
        if (dir[m] != pdir[m]) dir_chg[m] = cyc;
        if (step[m] && !pstep[m]) begin
          chk(cyc - dir_chg[m] >= S, "R3 dir setup before step", cyc - dir_chg[m], S);
          if (ev_n < 512) begin
            ev_mot[ev_n] = m; ev_dir[ev_n] = dir[m]; ev_t[ev_n] = cyc;
          end
          ev_n++;
        end
        if (step[m]) hi_len[m]++;
        else begin
          if (pstep[m] && !aborted) chk(hi_len[m] == P, "R4 pulse width", hi_len[m], P);
          hi_len[m] = 0;
        end
      end
    end
    pstep = step;
    pdir  = dir;
  end

  int exp_mot [512], exp_dir [512], exp_gap [512];
  int exp_n = 0, base = 0;

  task automatic add_exp(input logic [1:0] d, input logic [N*32-1:0] s);
    int prev_ivl;
    prev_ivl = -1;
    for (int k = 0; k < N; k++) begin
      logic [31:0] e;
      e = s[k*32 +: 32];
      if (e[30:0] == 0) break;
      exp_mot[exp_n] = int'(e[31]);
      exp_dir[exp_n] = int'(d[e[31]]);
      exp_gap[exp_n] = (prev_ivl < 0) ? 0 : prev_ivl + S + 2;
      prev_ivl = int'(e[30:0]);
      exp_n++;
    end
  endtask

  task automatic push(input logic [7:0] kind, input logic [1:0] d, input logic [N*32-1:0] s);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_kind = kind; cmd_dir = d; cmd_steps = s;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_kind = '0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 5000 && !empty; i++) @(negedge clk);
    repeat (20) @(negedge clk);
  endtask

  task automatic start_log();
    base = ev_n; exp_n = 0;
  endtask

  task automatic check_log(input string tag);
    chk(ev_n - base == exp_n, {tag, " step count"}, ev_n - base, exp_n);
    for (int k = 0; k < exp_n && k < ev_n - base; k++) begin
      chk(ev_mot[base+k] == exp_mot[k], {tag, " motor select"}, ev_mot[base+k], exp_mot[k]);
      chk(ev_dir[base+k] == exp_dir[k], {tag, " direction"}, ev_dir[base+k], exp_dir[k]);
      if (exp_gap[k] != 0 && k > 0)
        chk(ev_t[base+k] - ev_t[base+k-1] == exp_gap[k], {tag, " R5 spacing"},
            ev_t[base+k] - ev_t[base+k-1], exp_gap[k]);
    end
  endtask

  function automatic logic [31:0] ent(input bit m, input int ivl);
    return {m, 31'(ivl)};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [N*32-1:0] s, sa, sb;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(step == 0, "R1 step low", step, 0);
    chk(dir == 0, "R1 dir low", dir, 0);
    chk(empty == 1, "R1 empty", empty, 1);
    chk(full == 0, "R1 not full", full, 0);
    chk(overflow == 0, "R1 no overflow", overflow, 0);

    // R2 R5 R6: sweep motor patterns and direction pairs
    for (int i = 0; i < 32; i++) begin
      for (int k = 0; k < N; k++) s[k*32 +: 32] = ent(i[k % 4], P + ((i + k) % 4));
      start_log();
      add_exp(2'(i / 8), s);
      push(8'd0, 2'(i / 8), s);
      wait_idle();
      check_log("R2 R6 sweep");
    end

    // R7 zero interval ends the command early
    s = '0;
    s[0 +: 32] = ent(1, 5); s[32 +: 32] = ent(0, 0);
    s[64 +: 32] = ent(0, 6); s[96 +: 32] = ent(1, 7);
    start_log(); add_exp(2'b10, s); push(8'd0, 2'b10, s); wait_idle();
    check_log("R7 terminator");
    s = '0;
    s[32 +: 32] = ent(1, 5);
    start_log(); push(8'd0, 2'b11, s); wait_idle();
    check_log("R7 leading zero");
    chk(empty == 1, "R7 retired", empty, 1);

    // R8 R9: fill queue, drop third write, order preserved
    for (int k = 0; k < N; k++) begin
      sa[k*32 +: 32] = ent(k[0], 4 + k);
      sb[k*32 +: 32] = ent(!k[0], 6);
      s[k*32 +: 32]  = ent(0, 9);
    end
    start_log();
    add_exp(2'b01, sa); add_exp(2'b10, sb);
    push(8'd0, 2'b01, sa);
    push(8'd0, 2'b10, sb);
    chk(full == 1, "R8 full at depth", full, 1);
    push(8'd0, 2'b11, s);
    chk(overflow == 1, "R9 overflow set", overflow, 1);
    wait_idle();
    check_log("R8 R9 queue order");
    chk(overflow == 1, "R9 overflow sticky", overflow, 1);

    // R8 write accepted while running
    start_log();
    add_exp(2'b11, sa); add_exp(2'b00, sb);
    push(8'd0, 2'b11, sa);
    for (int i = 0; i < 200 && step == 0; i++) @(negedge clk);
    push(8'd0, 2'b00, sb);
    wait_idle();
    check_log("R8 write while running");

    // R10 stop during a pulse with a move waiting
    for (int k = 0; k < N; k++) s[k*32 +: 32] = ent(k[0], 40);
    start_log();
    push(8'd0, 2'b01, s);
    push(8'd0, 2'b10, s);
    for (int i = 0; i < 200 && step == 0; i++) @(negedge clk);
    chk(step != 0, "R10 pulse seen before stop", step, 1);
    aborted = 1;
    cmd_valid = 1'b1; cmd_kind = 8'd7;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_kind = '0;
    chk(step == 0, "R10 step dropped", step, 0);
    chk(empty == 1, "R10 queue flushed", empty, 1);
    repeat (300) @(negedge clk);
    aborted = 0;
    chk(ev_n - base == 1, "R10 no steps after stop", ev_n - base, 1);
    chk(empty == 1, "R10 stop not queued", empty, 1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule